// File: doc/BRIEF.md
# IR Raw Symbol Capture Controller

This block receives a demodulated infrared line and measures it in raw form. The line passes through a flop synchroniser. A timebase that software programs with the input clock rate then measures every active phase and every idle phase in 10 µs units. Each symbol is one active phase and the idle phase after it. It is packed into a 32-bit word and written into a receive FIFO, which software drains through a small register bus. Protocol decoding is left to software.

A programmable maximum symbol width marks the end of a stream. When the active and idle durations of the open symbol add up to that width, the idle part is cut short, the word is stored and a timeout is flagged. If a symbol completes while the FIFO is full, the symbol is dropped and an overflow flag is set. The stored symbols are kept, and software must drain them itself. Three status flags (enough symbols stored, timeout, overflow) are each maskable and are ORed onto one interrupt line.

Software brings the block up in this order: write 1 to the enable register, wait until the busy register reads zero, program the configuration, clear the mask, then write any value to the start register.

Top module: `ir_cap`

## Requirements
- R1: Register word addresses on `bus_addr` are: 0 enable, 1 config, 2 busy, 3 symbol count, 4 symbol data, 5 mask, 6 status, 7 clear, 8 start. After reset, config reads 0x3E800000, mask reads 7, and status, count, busy and `irq` are all 0.
- R2: Writing 1 to enable (bit 0) makes busy read nonzero for INIT_CYCLES clocks and then 0. Any write to enable empties the FIFO, clears all status flags and stops capture. A start write is ignored unless enable is 1 and busy is 0.
- R3: Config bits [6:0] hold F. One duration unit is 10*(F+1) clocks, and a phase lasting N clocks records floor(N / (10*(F+1))) units. Capture runs only while config bit 7 is 1.
- R4: A symbol word holds the active-phase duration in bits [15:0] and the idle-phase duration in bits [31:16]. The word is stored when the next active phase begins.
- R5: Config bits [15:14] select the polarity. Value 0 makes a low line the active phase and a high line the idle phase. Value 1 makes a high line the active phase.
- R6: Config bits [31:16] hold the maximum width W. The active count stops at W. When active plus idle reaches W, the word is stored with its idle field equal to W minus the active field, or 0 if the active field is already W. Status bit 9 (timeout) is then set, and capture waits for the next active phase.
- R7: The count register returns the number of stored words. A read of the data register returns the oldest word and removes it. A data read while the FIFO is empty returns 0 and changes nothing.
- R8: With FIFO_DEPTH (64) words stored, a newly completed symbol is discarded and status bit 10 (overflow) is set. The stored words stay unchanged. Writing 1 to clear bit 18 clears overflow.
- R9: Status bit 8 is set when a stored word leaves the count above config field [13:8]. Writing 1 to clear bit 16 clears bit 8, and writing 1 to clear bit 17 clears timeout.
- R10: Mask bits [2:0] mask the flags at status bits 8, 9 and 10 respectively (1 = masked). Status bits [26:24] read the unmasked flags, and `irq` is their OR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ir_in | input | 1 | Demodulated IR line, asynchronous |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the FIFO on the data address) |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | OR of the unmasked status flags |

## Verification
The bench sends symbols at several timebase settings. It checks the packed words against durations computed from the clock counts. An error in the unit timebase or an off-by-one at a phase boundary would show up as a wrong field. Some streams run past the maximum width, or hold the active level longer than that width. A design that failed to truncate or to saturate would store an idle field that breaks the sum rule, or would never flag a timeout. The bench fills the FIFO one symbol past its depth and drains it. A design that flushed the FIFO, or that overwrote the oldest word on overflow, would return the wrong head word or the wrong count. Further tests cover a start issued while busy, capture with raw mode off, inverted polarity, and a level threshold crossed one symbol at a time. These catch capture that starts early, a swapped polarity, and a receive flag raised one symbol too soon.

// File: rtl/ir_cap_pkg.sv
`timescale 1ns/1ps
package ir_cap_pkg;

   localparam int unsigned ADDR_W = 4;
   localparam int unsigned DATA_W = 32;
   localparam int unsigned DUR_W  = 16;

   // register word addresses
   localparam logic [ADDR_W-1:0] RA_ENABLE = 4'd0;
   localparam logic [ADDR_W-1:0] RA_CONFIG = 4'd1;
   localparam logic [ADDR_W-1:0] RA_BUSY   = 4'd2;
   localparam logic [ADDR_W-1:0] RA_COUNT  = 4'd3;
   localparam logic [ADDR_W-1:0] RA_DATA   = 4'd4;
   localparam logic [ADDR_W-1:0] RA_MASK   = 4'd5;
   localparam logic [ADDR_W-1:0] RA_STATUS = 4'd6;
   localparam logic [ADDR_W-1:0] RA_CLEAR  = 4'd7;
   localparam logic [ADDR_W-1:0] RA_START  = 4'd8;

   // config field placement
   localparam int unsigned CF_FREQ_LSB = 0;
   localparam int unsigned CF_FREQ_W   = 7;
   localparam int unsigned CF_RAW_BIT  = 7;
   localparam int unsigned CF_LVL_LSB  = 8;
   localparam int unsigned CF_LVL_W    = 6;
   localparam int unsigned CF_FMT_LSB  = 14;
   localparam int unsigned CF_FMT_W    = 2;
   localparam int unsigned CF_MAXW_LSB = 16;

   localparam logic [DATA_W-1:0] CFG_RESET = 32'h3E80_0000;

   // flag order inside the 3-bit status group
   localparam int unsigned FL_RX  = 0;
   localparam int unsigned FL_TO  = 1;
   localparam int unsigned FL_OVF = 2;
   localparam int unsigned ST_RAW_LSB = 8;
   localparam int unsigned ST_MSK_LSB = 24;
   localparam int unsigned CLR_LSB    = 16;

   typedef enum logic [1:0] {
      CAP_IDLE  = 2'd0,
      CAP_PULSE = 2'd1,
      CAP_SPACE = 2'd2
   } cap_state_e;

   typedef struct packed {
      logic [DUR_W-1:0] space;
      logic [DUR_W-1:0] pulse;
   } sym_word_t;

endpackage

// File: rtl/ir_cap_sync.sv
`timescale 1ns/1ps
module ir_cap_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   initial begin
      assert (STAGES >= 2) else $error("ir_cap_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk) begin
      if (!rst_n) chain[0] <= RST_VAL;
      else        chain[0] <= d;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) chain[i] <= RST_VAL;
         else        chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/ir_cap_timer.sv
`timescale 1ns/1ps
module ir_cap_timer #(
   parameter int unsigned FREQ_W  = 7,
   parameter int unsigned UNIT_US = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic [FREQ_W-1:0] freq_m1,
   output logic              tick
);

   localparam int unsigned CNT_W = $clog2((2**FREQ_W) * UNIT_US + 1);

   initial begin
      assert (UNIT_US >= 2) else $error("ir_cap_timer: UNIT_US must be at least 2");
   end

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] limit;

   // clocks per unit minus one: (F+1) clocks per microsecond, UNIT_US of them
   assign limit = (CNT_W'(freq_m1) + CNT_W'(1)) * CNT_W'(UNIT_US) - CNT_W'(1);
   assign tick  = !restart && (cnt == limit);

   // restart loads 1: the restart clock is the first clock of the new phase
   always_ff @(posedge clk) begin
      if (!rst_n)            cnt <= '0;
      else if (restart)      cnt <= CNT_W'(1);
      else if (cnt == limit) cnt <= '0;
      else                   cnt <= cnt + CNT_W'(1);
   end

   // R3: a unit tick is never followed directly by another
   assert_tick_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

endmodule

// File: rtl/ir_cap_sym.sv
`timescale 1ns/1ps
module ir_cap_sym
   import ir_cap_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             line,
   input  logic             active_lvl,
   input  logic [DUR_W-1:0] maxw,
   input  logic             tick,
   output logic             restart,
   output logic             push,
   output logic             timeout,
   output sym_word_t        word
);

   cap_state_e       state, nstate;
   logic [DUR_W-1:0] pulse_q, space_q;
   logic [DUR_W:0]   sum;
   logic             active, reach;
   logic [DUR_W-1:0] trunc;

   assign active = (line == active_lvl);
   assign sum    = {1'b0, pulse_q} + {1'b0, space_q};
   assign reach  = (sum >= {1'b0, maxw});
   assign trunc  = (pulse_q >= maxw) ? '0 : (maxw - pulse_q);

   always_comb begin
      nstate     = state;
      restart    = 1'b0;
      push       = 1'b0;
      timeout    = 1'b0;
      word.pulse = pulse_q;
      word.space = space_q;
      unique case (state)
         CAP_IDLE: begin
            if (active) begin
               restart = 1'b1;
               nstate  = CAP_PULSE;
            end
         end
         CAP_PULSE: begin
            if (!active) begin
               restart = 1'b1;
               nstate  = CAP_SPACE;
            end
         end
         CAP_SPACE: begin
            if (active) begin
               restart = 1'b1;
               push    = 1'b1;
               nstate  = CAP_PULSE;
            end else if (reach) begin
               push       = 1'b1;
               timeout    = 1'b1;
               word.space = trunc;
               nstate     = CAP_IDLE;
            end
         end
         default: nstate = CAP_IDLE;
      endcase
      if (!run) begin
         nstate  = CAP_IDLE;
         restart = 1'b0;
         push    = 1'b0;
         timeout = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= CAP_IDLE;
         pulse_q <= '0;
         space_q <= '0;
      end else begin
         state <= nstate;
         if (nstate == CAP_PULSE && state != CAP_PULSE) begin
            pulse_q <= '0;
            space_q <= '0;
         end else if (state == CAP_PULSE && active && tick) begin
            if (pulse_q < maxw) pulse_q <= pulse_q + 1'b1;
         end else if (state == CAP_SPACE && !active && tick) begin
            if (space_q != '1) space_q <= space_q + 1'b1;
         end
      end
   end

   // R6: an end-of-stream word never exceeds the maximum width
   assert_trunc_sum_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (push && timeout) |-> (({1'b0, word.pulse} + {1'b0, word.space} == {1'b0, maxw})
                             || (word.space == '0)));

   // R6: the active count never climbs past the maximum width
   assert_pulse_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == CAP_PULSE && pulse_q == maxw && $stable(maxw)) |=> (pulse_q == maxw || state != CAP_PULSE));

endmodule

// File: rtl/ir_cap_fifo.sv
`timescale 1ns/1ps
module ir_cap_fifo #(
   parameter int unsigned WIDTH = 32,
   parameter int unsigned DEPTH = 64
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     flush,
   input  logic                     push,
   input  logic [WIDTH-1:0]         din,
   input  logic                     pop,
   output logic [WIDTH-1:0]         dout,
   output logic [$clog2(DEPTH):0]   count,
   output logic                     full,
   output logic                     empty
);

   localparam int unsigned AW = $clog2(DEPTH);
   localparam int unsigned CW = AW + 1;

   initial begin
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("ir_cap_fifo: DEPTH must be a power of two, at least 2");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr;
   logic             push_ok, pop_ok;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign dout    = empty ? '0 : mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + 1'b1;
         if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
         unique case ({push_ok, pop_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   // R8: a push into a full FIFO leaves it full and untouched
   assert_full_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !flush) |=> full);

   // R7: occupancy stays within the depth
   assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));

endmodule

// File: rtl/ir_cap.sv
`timescale 1ns/1ps
module ir_cap
   import ir_cap_pkg::*;
#(
   parameter int unsigned FIFO_DEPTH  = 64,
   parameter int unsigned INIT_CYCLES = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned UNIT_US     = 10
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ir_in,
   input  logic        bus_wr,
   input  logic        bus_rd,
   input  logic [3:0]  bus_addr,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   output logic        irq
);

   localparam int unsigned BUSY_W = $clog2(INIT_CYCLES + 1);
   localparam int unsigned CNT_W  = $clog2(FIFO_DEPTH) + 1;

   initial begin
      assert (INIT_CYCLES >= 1) else $error("ir_cap: INIT_CYCLES must be at least 1");
   end

   // register state
   logic              en_q, run_q;
   logic [BUSY_W-1:0] busy_cnt;
   logic [31:0]       cfg_q;
   logic [2:0]        mask_q;
   logic [2:0]        flags_q;

   // decoded config fields
   logic [CF_FREQ_W-1:0] cf_freq;
   logic [CF_LVL_W-1:0]  cf_lvl;
   logic [CF_FMT_W-1:0]  cf_fmt;
   logic [DUR_W-1:0]     cf_maxw;
   logic                 cf_raw;

   assign cf_freq = cfg_q[CF_FREQ_LSB +: CF_FREQ_W];
   assign cf_raw  = cfg_q[CF_RAW_BIT];
   assign cf_lvl  = cfg_q[CF_LVL_LSB +: CF_LVL_W];
   assign cf_fmt  = cfg_q[CF_FMT_LSB +: CF_FMT_W];
   assign cf_maxw = cfg_q[CF_MAXW_LSB +: DUR_W];

   // bus decode
   logic wr_enable, wr_config, wr_mask, wr_clear, wr_start, rd_data;
   logic [2:0] clr_bits;

   assign wr_enable = bus_wr && (bus_addr == RA_ENABLE);
   assign wr_config = bus_wr && (bus_addr == RA_CONFIG);
   assign wr_mask   = bus_wr && (bus_addr == RA_MASK);
   assign wr_clear  = bus_wr && (bus_addr == RA_CLEAR);
   assign wr_start  = bus_wr && (bus_addr == RA_START);
   assign rd_data   = bus_rd && (bus_addr == RA_DATA);
   assign clr_bits  = wr_clear ? bus_wdata[CLR_LSB +: 3] : 3'b000;

   // capture datapath
   logic      line_s, active_lvl, cap_run;
   logic      unit_tick, phase_restart;
   logic      sym_push, sym_timeout;
   sym_word_t sym_word;
   logic [DATA_W-1:0] fifo_dout;
   logic [CNT_W-1:0]  fifo_count;
   logic              fifo_full, fifo_empty;

   assign cap_run    = run_q && cf_raw;
   assign active_lvl = (cf_fmt == 2'd1);

   ir_cap_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(ir_in), .q(line_s)
   );

   ir_cap_timer #(.FREQ_W(CF_FREQ_W), .UNIT_US(UNIT_US)) u_timer (
      .clk(clk), .rst_n(rst_n), .restart(phase_restart),
      .freq_m1(cf_freq), .tick(unit_tick)
   );

   ir_cap_sym u_sym (
      .clk(clk), .rst_n(rst_n), .run(cap_run), .line(line_s),
      .active_lvl(active_lvl), .maxw(cf_maxw), .tick(unit_tick),
      .restart(phase_restart), .push(sym_push), .timeout(sym_timeout),
      .word(sym_word)
   );

   ir_cap_fifo #(.WIDTH(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .flush(wr_enable),
      .push(sym_push), .din(sym_word), .pop(rd_data),
      .dout(fifo_dout), .count(fifo_count),
      .full(fifo_full), .empty(fifo_empty)
   );

   // control registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         run_q    <= 1'b0;
         busy_cnt <= '0;
         cfg_q    <= CFG_RESET;
         mask_q   <= 3'b111;
      end else begin
         if (busy_cnt != '0) busy_cnt <= busy_cnt - 1'b1;
         if (wr_enable) begin
            en_q  <= bus_wdata[0];
            run_q <= 1'b0;
            if (bus_wdata[0]) busy_cnt <= BUSY_W'(INIT_CYCLES);
         end
         if (wr_start && en_q && busy_cnt == '0) run_q <= 1'b1;
         if (wr_config) cfg_q  <= bus_wdata;
         if (wr_mask)   mask_q <= bus_wdata[2:0];
      end
   end

   // status flags: a set in the same clock wins over a clear
   logic [2:0] flag_set;
   logic       ovf_drop;

   assign ovf_drop = sym_push && fifo_full;
   always_comb begin
      flag_set         = 3'b000;
      flag_set[FL_RX]  = sym_push && !fifo_full &&
                         ((32'(fifo_count) + 32'd1) > 32'(cf_lvl));
      flag_set[FL_TO]  = sym_timeout;
      flag_set[FL_OVF] = ovf_drop;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || wr_enable) flags_q <= 3'b000;
      else                     flags_q <= flag_set | (flags_q & ~clr_bits);
   end

   logic [2:0] flags_vis;
   assign flags_vis = flags_q & ~mask_q;
   assign irq       = |flags_vis;

   // read mux
   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         RA_ENABLE: bus_rdata = {31'b0, en_q};
         RA_CONFIG: bus_rdata = cfg_q;
         RA_BUSY:   bus_rdata = 32'(busy_cnt);
         RA_COUNT:  bus_rdata = 32'(fifo_count);
         RA_DATA:   bus_rdata = fifo_dout;
         RA_MASK:   bus_rdata = {29'b0, mask_q};
         RA_STATUS: begin
            bus_rdata[ST_RAW_LSB +: 3] = flags_q;
            bus_rdata[ST_MSK_LSB +: 3] = flags_vis;
         end
         default:   bus_rdata = '0;
      endcase
   end

   // R2: an enable write of 1 makes the block busy on the next clock
   assert_busy_on_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == RA_ENABLE && bus_wdata[0]) |=> (busy_cnt != '0));

   // R8: overflow rises only after a symbol met a full FIFO
   assert_ovf_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags_q[FL_OVF]) |-> $past(sym_push && fifo_full));

   // R10: with every flag masked the interrupt line stays low
   assert_irq_masked_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == 3'b111) |-> !irq);

   // R2: no capture while the block is initialising
   assert_no_push_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_cnt != '0) |-> !run_q);

endmodule

// File: tb/ir_cap_test.sv
`timescale 1ns/1ps
module ir_cap_test;

   localparam int CLK_PERIOD = 10;
   localparam int MAXW       = 40;
   localparam int NVEC       = 7;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ir_in = 1'b1;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ir_cap uut (
      .clk(clk), .rst_n(rst_n), .ir_in(ir_in),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   // stimulus/expectation table: freq field, active units, idle units, first word
   typedef struct packed {
      logic [6:0]  freq;
      logic [15:0] pulse;
      logic [15:0] space;
      logic [31:0] exp0;
   } vec_t;

   localparam vec_t VECS [NVEC] = '{
      '{7'd0, 16'd3,  16'd5,  32'h0005_0003},
      '{7'd0, 16'd1,  16'd1,  32'h0001_0001},
      '{7'd1, 16'd7,  16'd2,  32'h0002_0007},
      '{7'd3, 16'd2,  16'd9,  32'h0009_0002},
      '{7'd0, 16'd10, 16'd35, 32'h001E_000A},
      '{7'd2, 16'd38, 16'd1,  32'h0001_0026},
      '{7'd0, 16'd45, 16'd3,  32'h0000_0028}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic hold_line(input logic lvl, input int cycles);
      @(negedge clk);
      ir_in = lvl;
      repeat (cycles - 1) @(negedge clk);
   endtask

   function automatic logic [31:0] cfg_word(input int freq, input int lvl, input int fmt,
                                             input bit raw, input int maxw);
      return {16'(maxw), 2'(fmt), 6'(lvl), raw, 7'(freq)};
   endfunction

   task automatic wait_idle();
      logic [31:0] v;
      for (int i = 0; i < 200; i++) begin
         bus_read(4'd2, v);
         if (v == 0) break;
      end
   endtask

   task automatic setup(input int freq, input int lvl, input int fmt, input bit raw);
      bus_write(4'd0, 32'd1);
      wait_idle();
      bus_write(4'd1, cfg_word(freq, lvl, fmt, raw, MAXW));
      bus_write(4'd5, 32'd0);
      bus_write(4'd8, 32'h5A);
   endtask

   initial begin
      repeat (CLK_PERIOD * 20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'd0, 32'd1);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      int per;

      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      bus_read(4'd1, v); check("R1 config reset", v, 32'h3E80_0000);
      bus_read(4'd5, v); check("R1 mask reset", v, 32'd7);
      bus_read(4'd6, v); check("R1 status reset", v, 32'd0);
      bus_read(4'd3, v); check("R1 count reset", v, 32'd0);
      bus_read(4'd2, v); check("R1 busy reset", v, 32'd0);
      check("R1 irq reset", {31'b0, irq}, 32'd0);

      // R7 empty read
      bus_read(4'd4, v); check("R7 empty data read", v, 32'd0);
      bus_read(4'd3, v); check("R7 count after empty read", v, 32'd0);

      // R2 busy window and start ignored while busy
      bus_write(4'd1, cfg_word(0, 0, 0, 1'b1, MAXW));
      bus_write(4'd0, 32'd1);
      bus_read(4'd2, v); check("R2 busy after enable", {31'b0, v != 0}, 32'd1);
      bus_write(4'd8, 32'd1);
      repeat (20) @(negedge clk);
      bus_read(4'd2, v); check("R2 busy ends", v, 32'd0);
      hold_line(1'b0, 20); hold_line(1'b1, 20); hold_line(1'b0, 10);
      hold_line(1'b1, (MAXW + 3) * 10);
      bus_read(4'd3, v); check("R2 start while busy ignored", v, 32'd0);
      bus_write(4'd8, 32'd1);
      hold_line(1'b0, 20); hold_line(1'b1, 20); hold_line(1'b0, 10);
      hold_line(1'b1, (MAXW + 3) * 10);
      bus_read(4'd3, v); check("R2 start after busy", v, 32'd2);
      bus_write(4'd0, 32'd1);
      bus_read(4'd3, v); check("R2 enable flushes fifo", v, 32'd0);
      bus_read(4'd6, v); check("R2 enable clears status", v, 32'd0);

      // R3 raw mode off: nothing captured
      wait_idle();
      bus_write(4'd1, cfg_word(0, 0, 0, 1'b0, MAXW));
      bus_write(4'd8, 32'd1);
      hold_line(1'b0, 30); hold_line(1'b1, 30); hold_line(1'b0, 10);
      hold_line(1'b1, (MAXW + 3) * 10);
      bus_read(4'd3, v); check("R3 raw bit clear blocks capture", v, 32'd0);

      // table walk: R3 R4 R6
      for (int k = 0; k < NVEC; k++) begin
         per = 10 * (int'(VECS[k].freq) + 1);
         ir_in = 1'b1;
         setup(int'(VECS[k].freq), 0, 0, 1'b1);
         hold_line(1'b0, int'(VECS[k].pulse) * per);
         hold_line(1'b1, int'(VECS[k].space) * per);
         hold_line(1'b0, per);
         hold_line(1'b1, (MAXW + 3) * per);
         bus_read(4'd3, v); check($sformatf("R4 vec%0d count", k), v, 32'd2);
         bus_read(4'd4, v); check($sformatf("R3 R6 vec%0d first word", k), v, VECS[k].exp0);
         bus_read(4'd4, v); check($sformatf("R6 vec%0d end word", k), v, 32'h0027_0001);
         bus_read(4'd6, v); check($sformatf("R6 vec%0d timeout flag", k), (v >> 9) & 32'd1, 32'd1);
      end

      // R5 high-active polarity
      ir_in = 1'b0;
      setup(0, 0, 1, 1'b1);
      hold_line(1'b1, 30); hold_line(1'b0, 40); hold_line(1'b1, 10);
      hold_line(1'b0, (MAXW + 3) * 10);
      bus_read(4'd3, v); check("R5 inverted count", v, 32'd2);
      bus_read(4'd4, v); check("R5 inverted word", v, 32'h0004_0003);
      ir_in = 1'b1;

      // R9 level threshold, clears
      setup(0, 2, 0, 1'b1);
      hold_line(1'b0, 20); hold_line(1'b1, 20);
      hold_line(1'b0, 20); hold_line(1'b1, 20);
      hold_line(1'b0, 30);
      bus_read(4'd6, v); check("R9 rx not set at level", (v >> 8) & 32'd1, 32'd0);
      hold_line(1'b1, 20);
      hold_line(1'b0, 30);
      bus_read(4'd6, v); check("R9 rx set above level", (v >> 8) & 32'd1, 32'd1);
      check("R10 irq from rx", {31'b0, irq}, 32'd1);
      bus_write(4'd7, 32'h0001_0000);
      bus_read(4'd6, v); check("R9 rx clear", v & 32'h0000_0700, 32'd0);
      hold_line(1'b1, (MAXW + 3) * 10);
      bus_read(4'd6, v); check("R9 R6 rx and timeout", v, 32'h0300_0300);
      bus_write(4'd5, 32'd7);
      bus_read(4'd6, v); check("R10 all masked status", v, 32'h0000_0300);
      check("R10 irq masked", {31'b0, irq}, 32'd0);
      bus_write(4'd5, 32'd1);
      bus_read(4'd6, v); check("R10 rx masked only", v, 32'h0200_0300);
      check("R10 irq timeout", {31'b0, irq}, 32'd1);
      bus_write(4'd7, 32'h0003_0000);
      bus_read(4'd6, v); check("R9 clear rx and timeout", v, 32'd0);

      // R8 overflow keeps contents
      setup(0, 0, 0, 1'b1);
      for (int s = 0; s < 65; s++) begin
         hold_line(1'b0, 10);
         hold_line(1'b1, 10);
      end
      hold_line(1'b1, (MAXW + 3) * 10);
      bus_read(4'd3, v); check("R8 count at full", v, 32'd64);
      bus_read(4'd6, v); check("R8 overflow flag", (v >> 10) & 32'd1, 32'd1);
      check("R8 irq on overflow", {31'b0, irq}, 32'd1);
      bus_read(4'd4, v); check("R8 head preserved", v, 32'h0001_0001);
      for (int s = 1; s < 64; s++) bus_read(4'd4, v);
      bus_read(4'd3, v); check("R7 drained", v, 32'd0);
      bus_write(4'd7, 32'h0004_0000);
      bus_read(4'd6, v); check("R8 overflow clear", (v >> 10) & 32'd1, 32'd0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule